// File: doc/BRIEF.md
# Multi-Policy Page Replacement Selector

This block keeps usage bookkeeping for the small group of physical page frames handed to one process and, when a page fault is raised, names the frame that should be given up. For every frame it holds a present flag, a referenced flag, a modified (dirty) flag, the time the page was loaded, the time it was last touched and a count of how often it was touched in the current observation window. Timestamps come from an internal free-running time counter that advances once per clock; the observation window is a fixed number of cycles, after which all use counts start again from zero.

Three kinds of event arrive on the ports: a reference (frame index plus a read/write indication), a load (the named frame has just been filled with a new page) and a fault request carrying a policy code. The policy picks the ranking used by one shared comparison network: oldest arrival, oldest last use, or fewest uses in the window. Frames that hold no page always win over occupied ones. One cycle after the fault request the block presents the chosen frame index and whether that frame is dirty, qualified by a single-cycle valid pulse. Moving data to and from disk and storing page tables are left to the surrounding system.

Top module: `page_victim_sel`

## Requirements
- R1: After synchronous reset every frame reads as absent with referenced and modified clear, `victim_valid` is 0, and no frame's present flag ever returns to 0 afterwards.
- R2: A load of frame f sets its present flag, clears its referenced and modified flags and its use count, and stamps both its arrival and last-use times with the current time.
- R3: A reference to a present frame sets its referenced flag, stamps its last-use time with the current time and increments its use count; when `ref_write` is 1 it also sets the modified flag; a reference to an absent frame changes nothing.
- R4: If any frame is absent when a fault is requested, the victim is the absent frame with the lowest index, whatever the policy.
- R5: With policy code 0 (or code 3) and all frames present, the victim is the frame whose arrival time is oldest, measured as current time minus arrival time.
- R6: With policy code 1 and all frames present, the victim is the frame whose last use is oldest, measured as current time minus last-use time.
- R7: With policy code 2 and all frames present, the victim is the frame with the smallest use count; use counts are `USE_W` bits wide and stop at their maximum value instead of wrapping.
- R8: Every `WINDOW` cycles after reset all use counts clear; a reference in the clearing cycle leaves its frame with a count of 1.
- R9: When several frames rank equally under the active policy, the lowest frame index is chosen.
- R10: `victim_valid` is 1 exactly in the cycle after a cycle with `fault_req` high, and `victim_frame`/`victim_dirty` then reflect the state before any reference or load of the fault cycle; `victim_dirty` equals the chosen frame's modified flag.
- R11: When a load and a reference name the same frame in the same cycle, the load takes effect and the reference is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A frame reference occurs this cycle |
| ref_frame | input | $clog2(N_FRAMES) | Index of the referenced frame |
| ref_write | input | 1 | 1 for a write reference, 0 for a read |
| load_valid | input | 1 | A frame is filled with a new page this cycle |
| load_frame | input | $clog2(N_FRAMES) | Index of the filled frame |
| fault_req | input | 1 | Request a victim choice this cycle |
| fault_policy | input | 2 | 0 arrival order, 1 least recent use, 2 fewest uses, 3 arrival order |
| victim_valid | output | 1 | One-cycle pulse: victim outputs are valid |
| victim_frame | output | $clog2(N_FRAMES) | Chosen frame index |
| victim_dirty | output | 1 | Modified flag of the chosen frame |
| frame_present | output | N_FRAMES | Per-frame present flags |
| frame_referenced | output | N_FRAMES | Per-frame referenced flags |
| frame_modified | output | N_FRAMES | Per-frame modified flags |

## Verification
The delicate overlap is a fault request in the same cycle as a reference or a load: the victim must be chosen from the state before that cycle's update, while the update itself still lands. The bench provokes this by driving references, loads and faults from one pseudo-random stream so they coincide often, and judges each victim against a bench model that ranks the pre-update state. A second overlap, a load and a reference naming the same frame together, is forced directly and judged by the flag outputs in the following cycle.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

    typedef enum logic [1:0] {
        POL_ARRIVAL  = 2'd0,
        POL_RECENCY  = 2'd1,
        POL_SCARCITY = 2'd2,
        POL_ARRIVAL2 = 2'd3
    } policy_e;

    typedef struct packed {
        logic present;
        logic referenced;
        logic modified;
    } frame_flags_t;

    // Map a raw two-bit code onto the three rankings; the spare code ranks by arrival.
    function automatic policy_e norm_policy(input logic [1:0] code);
        policy_e p;
        p = policy_e'(code);
        if (p == POL_ARRIVAL2) p = POL_ARRIVAL;
        return p;
    endfunction

endpackage

// File: rtl/pvs_timebase.sv
module pvs_timebase #(
    parameter int STAMP_W = 16,
    parameter int WINDOW  = 64
) (
    input  logic               clk,
    input  logic               rst,
    output logic [STAMP_W-1:0] now,
    output logic               win_expire
);
    localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

    logic [WIN_W-1:0] win_cnt;

    assign win_expire = (win_cnt == WIN_W'(WINDOW - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            now     <= '0;
            win_cnt <= '0;
        end else begin
            now     <= now + 1'b1;
            win_cnt <= win_expire ? '0 : win_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pvs_frame_table.sv
module pvs_frame_table
    import pvs_pkg::*;
#(
    parameter int N_FRAMES = 4,
    parameter int STAMP_W  = 16,
    parameter int USE_W    = 3,
    localparam int IDX_W   = $clog2(N_FRAMES)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [STAMP_W-1:0]                now,
    input  logic                              win_expire,
    input  logic                              ref_valid,
    input  logic [IDX_W-1:0]                  ref_frame,
    input  logic                              ref_write,
    input  logic                              load_valid,
    input  logic [IDX_W-1:0]                  load_frame,
    output frame_flags_t [N_FRAMES-1:0]       flags,
    output logic [N_FRAMES-1:0][STAMP_W-1:0]  arrival,
    output logic [N_FRAMES-1:0][STAMP_W-1:0]  last_use,
    output logic [N_FRAMES-1:0][USE_W-1:0]    use_cnt
);
    frame_flags_t [N_FRAMES-1:0]       flags_n;
    logic [N_FRAMES-1:0][STAMP_W-1:0]  arrival_n, last_use_n;
    logic [N_FRAMES-1:0][USE_W-1:0]    use_cnt_n;

    always_comb begin
        flags_n    = flags;
        arrival_n  = arrival;
        last_use_n = last_use;
        use_cnt_n  = use_cnt;
        for (int i = 0; i < N_FRAMES; i++) begin
            if (win_expire) use_cnt_n[i] = '0;
            if (load_valid && load_frame == IDX_W'(i)) begin
                flags_n[i]    = '{present: 1'b1, referenced: 1'b0, modified: 1'b0};
                arrival_n[i]  = now;
                last_use_n[i] = now;
                use_cnt_n[i]  = '0;
            end else if (ref_valid && ref_frame == IDX_W'(i) && flags[i].present) begin
                flags_n[i].referenced = 1'b1;
                if (ref_write) flags_n[i].modified = 1'b1;
                last_use_n[i] = now;
                if (use_cnt_n[i] != {USE_W{1'b1}}) use_cnt_n[i] = use_cnt_n[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags    <= '0;
            arrival  <= '0;
            last_use <= '0;
            use_cnt  <= '0;
        end else begin
            flags    <= flags_n;
            arrival  <= arrival_n;
            last_use <= last_use_n;
            use_cnt  <= use_cnt_n;
        end
    end
endmodule

// File: rtl/pvs_victim_pick.sv
module pvs_victim_pick
    import pvs_pkg::*;
#(
    parameter int N_FRAMES = 4,
    parameter int STAMP_W  = 16,
    parameter int USE_W    = 3,
    localparam int IDX_W   = $clog2(N_FRAMES),
    localparam int KEY_W   = STAMP_W + 1
) (
    input  policy_e                           policy,
    input  logic [STAMP_W-1:0]                now,
    input  frame_flags_t [N_FRAMES-1:0]       flags,
    input  logic [N_FRAMES-1:0][STAMP_W-1:0]  arrival,
    input  logic [N_FRAMES-1:0][STAMP_W-1:0]  last_use,
    input  logic [N_FRAMES-1:0][USE_W-1:0]    use_cnt,
    output logic [IDX_W-1:0]                  pick
);
    // Larger key = better victim. Top bit marks an empty frame.
    logic [N_FRAMES-1:0][KEY_W-1:0] key;

    generate
        for (genvar g = 0; g < N_FRAMES; g++) begin : g_key
            logic [STAMP_W-1:0] metric;
            always_comb begin
                unique case (policy)
                    POL_RECENCY:  metric = now - last_use[g];
                    POL_SCARCITY: metric = STAMP_W'({USE_W{1'b1}} - use_cnt[g]);
                    default:      metric = now - arrival[g];
                endcase
            end
            assign key[g] = {~flags[g].present, metric};
        end
    endgenerate

    // Strictly-greater replacement keeps the lowest index on ties.
    always_comb begin
        logic [KEY_W-1:0] best;
        best = key[0];
        pick = '0;
        for (int i = 1; i < N_FRAMES; i++) begin
            if (key[i] > best) begin
                best = key[i];
                pick = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/page_victim_sel.sv
module page_victim_sel
    import pvs_pkg::*;
#(
    parameter int N_FRAMES = 4,
    parameter int STAMP_W  = 16,
    parameter int USE_W    = 3,
    parameter int WINDOW   = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ref_valid,
    input  logic [$clog2(N_FRAMES)-1:0] ref_frame,
    input  logic                        ref_write,
    input  logic                        load_valid,
    input  logic [$clog2(N_FRAMES)-1:0] load_frame,
    input  logic                        fault_req,
    input  logic [1:0]                  fault_policy,
    output logic                        victim_valid,
    output logic [$clog2(N_FRAMES)-1:0] victim_frame,
    output logic                        victim_dirty,
    output logic [N_FRAMES-1:0]         frame_present,
    output logic [N_FRAMES-1:0]         frame_referenced,
    output logic [N_FRAMES-1:0]         frame_modified
);
    localparam int IDX_W = $clog2(N_FRAMES);

    logic [STAMP_W-1:0]                now;
    logic                              win_expire;
    frame_flags_t [N_FRAMES-1:0]       flags;
    logic [N_FRAMES-1:0][STAMP_W-1:0]  arrival, last_use;
    logic [N_FRAMES-1:0][USE_W-1:0]    use_cnt;
    logic [IDX_W-1:0]                  pick;

    pvs_timebase #(.STAMP_W(STAMP_W), .WINDOW(WINDOW)) u_time (
        .clk(clk), .rst(rst), .now(now), .win_expire(win_expire)
    );

    pvs_frame_table #(.N_FRAMES(N_FRAMES), .STAMP_W(STAMP_W), .USE_W(USE_W)) u_table (
        .clk(clk), .rst(rst), .now(now), .win_expire(win_expire),
        .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
        .load_valid(load_valid), .load_frame(load_frame),
        .flags(flags), .arrival(arrival), .last_use(last_use), .use_cnt(use_cnt)
    );

    pvs_victim_pick #(.N_FRAMES(N_FRAMES), .STAMP_W(STAMP_W), .USE_W(USE_W)) u_pick (
        .policy(norm_policy(fault_policy)), .now(now), .flags(flags),
        .arrival(arrival), .last_use(last_use), .use_cnt(use_cnt), .pick(pick)
    );

    generate
        for (genvar g = 0; g < N_FRAMES; g++) begin : g_flags
            assign frame_present[g]    = flags[g].present;
            assign frame_referenced[g] = flags[g].referenced;
            assign frame_modified[g]   = flags[g].modified;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid <= 1'b0;
            victim_frame <= '0;
            victim_dirty <= 1'b0;
        end else begin
            victim_valid <= fault_req;
            if (fault_req) begin
                victim_frame <= pick;
                victim_dirty <= flags[pick].modified;
            end
        end
    end
endmodule

// File: rtl/page_victim_sel_chk.sv
module page_victim_sel_chk #(
    parameter int N_FRAMES = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        ref_valid,
    input logic [$clog2(N_FRAMES)-1:0] ref_frame,
    input logic                        ref_write,
    input logic                        load_valid,
    input logic [$clog2(N_FRAMES)-1:0] load_frame,
    input logic                        fault_req,
    input logic                        victim_valid,
    input logic [$clog2(N_FRAMES)-1:0] victim_frame,
    input logic [N_FRAMES-1:0]         frame_present,
    input logic [N_FRAMES-1:0]         frame_referenced,
    input logic [N_FRAMES-1:0]         frame_modified
);
    logic [N_FRAMES-1:0] pres_q;

    always_ff @(posedge clk) begin
        if (rst) pres_q <= '0;
        else     pres_q <= frame_present;
    end

    p_valid_after_fault_r10: assert property (@(posedge clk) disable iff (rst)
        fault_req |=> victim_valid);

    p_valid_needs_fault_r10: assert property (@(posedge clk) disable iff (rst)
        victim_valid |-> $past(fault_req));

    p_load_fresh_r2: assert property (@(posedge clk) disable iff (rst)
        load_valid |=> (frame_present[$past(load_frame)]
                        && !frame_referenced[$past(load_frame)]
                        && !frame_modified[$past(load_frame)]));

    p_write_dirty_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_write && frame_present[ref_frame]
         && !(load_valid && load_frame == ref_frame))
        |=> frame_modified[$past(ref_frame)]);

    p_absent_first_r4: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && !(&pres_q)) |-> !pres_q[victim_frame]);

    p_present_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        (frame_present & pres_q) == pres_q);
endmodule

bind page_victim_sel page_victim_sel_chk #(.N_FRAMES(N_FRAMES)) u_chk (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_write(ref_write), .load_valid(load_valid), .load_frame(load_frame),
    .fault_req(fault_req), .victim_valid(victim_valid), .victim_frame(victim_frame),
    .frame_present(frame_present), .frame_referenced(frame_referenced),
    .frame_modified(frame_modified)
);

// File: tb/page_victim_sel_tb.sv
`timescale 1ns/1ps
module page_victim_sel_tb;
    localparam int NF = 4;
    localparam int SW = 16;
    localparam int UW = 3;
    localparam int WIN = 16;
    localparam int UMAX = (1 << UW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_valid = 0, ref_write = 0, load_valid = 0, fault_req = 0;
    logic [1:0] ref_frame = 0, load_frame = 0, fault_policy = 0;
    logic victim_valid, victim_dirty;
    logic [1:0] victim_frame;
    logic [NF-1:0] frame_present, frame_referenced, frame_modified;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    page_victim_sel #(.N_FRAMES(NF), .STAMP_W(SW), .USE_W(UW), .WINDOW(WIN)) u_dut (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_frame(ref_frame),
        .ref_write(ref_write), .load_valid(load_valid), .load_frame(load_frame),
        .fault_req(fault_req), .fault_policy(fault_policy),
        .victim_valid(victim_valid), .victim_frame(victim_frame),
        .victim_dirty(victim_dirty), .frame_present(frame_present),
        .frame_referenced(frame_referenced), .frame_modified(frame_modified)
    );

    // Bench model built from the requirements.
    logic [NF-1:0] m_pres, m_ref, m_mod;
    logic [SW-1:0] m_arr [NF];
    logic [SW-1:0] m_last [NF];
    int            m_cnt [NF];
    logic [SW-1:0] m_now;
    int            m_win;
    bit            exp_pend;
    int            exp_frame;
    bit            exp_dirty;
    string         exp_tag;

    function automatic int model_pick(input logic [1:0] pol, output string tag);
        int best;
        for (int i = 0; i < NF; i++) if (!m_pres[i]) begin
            tag = "R4/R9 empty-first";
            return i;
        end
        best = 0;
        for (int i = 1; i < NF; i++) begin
            if (pol == 2'd1) begin
                if (SW'(m_now - m_last[i]) > SW'(m_now - m_last[best])) best = i;
            end else if (pol == 2'd2) begin
                if (m_cnt[i] < m_cnt[best]) best = i;
            end else begin
                if (SW'(m_now - m_arr[i]) > SW'(m_now - m_arr[best])) best = i;
            end
        end
        tag = (pol == 2'd1) ? "R6/R9 recency" : (pol == 2'd2) ? "R7/R8/R9 use-count" : "R5/R9 arrival";
        return best;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_pres = '0; m_ref = '0; m_mod = '0; m_now = '0; m_win = 0; exp_pend = 0;
            for (int i = 0; i < NF; i++) begin m_arr[i] = '0; m_last[i] = '0; m_cnt[i] = 0; end
        end else begin
            bit expire;
            exp_pend = fault_req;
            if (fault_req) begin
                exp_frame = model_pick(fault_policy, exp_tag);
                exp_dirty = m_mod[exp_frame];
            end
            expire = (m_win == WIN - 1);
            if (expire) for (int i = 0; i < NF; i++) m_cnt[i] = 0;
            if (ref_valid && m_pres[ref_frame] && !(load_valid && load_frame == ref_frame)) begin
                m_ref[ref_frame] = 1'b1;
                if (ref_write) m_mod[ref_frame] = 1'b1;
                m_last[ref_frame] = m_now;
                if (m_cnt[ref_frame] < UMAX) m_cnt[ref_frame]++;
            end
            if (load_valid) begin
                m_pres[load_frame] = 1'b1; m_ref[load_frame] = 1'b0; m_mod[load_frame] = 1'b0;
                m_arr[load_frame] = m_now; m_last[load_frame] = m_now; m_cnt[load_frame] = 0;
            end
            m_win = expire ? 0 : m_win + 1;
            m_now = m_now + 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare outputs with the model (called at a falling edge).
    task automatic compare(input string flag_req);
        check(victim_valid == exp_pend, "R10", "victim_valid", victim_valid, exp_pend);
        if (exp_pend && victim_valid) begin
            check(victim_frame == 2'(exp_frame), exp_tag, "victim_frame", victim_frame, exp_frame);
            check(victim_dirty == exp_dirty, "R10", "victim_dirty", victim_dirty, exp_dirty);
        end
        check(frame_present == m_pres, flag_req, "present", frame_present, m_pres);
        check(frame_referenced == m_ref, flag_req, "referenced", frame_referenced, m_ref);
        check(frame_modified == m_mod, flag_req, "modified", frame_modified, m_mod);
    endtask

    // Drive one cycle at a falling edge, then compare at the next falling edge.
    task automatic cyc(input bit rv, input int rf, input bit rw, input bit lv, input int lf,
                       input bit fq, input int fp, input string flag_req);
        ref_valid = rv; ref_frame = 2'(rf); ref_write = rw;
        load_valid = lv; load_frame = 2'(lf);
        fault_req = fq; fault_policy = 2'(fp);
        @(negedge clk);
        ref_valid = 0; load_valid = 0; fault_req = 0;
        compare(flag_req);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, "R2/R3");
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(victim_valid == 0, "R1", "victim_valid after reset", victim_valid, 0);
        check(frame_present == 0, "R1", "present after reset", frame_present, 0);
        check(frame_modified == 0 && frame_referenced == 0, "R1", "flags after reset",
              frame_modified | frame_referenced, 0);

        // R4 R9: all empty -> frame 0
        cyc(0, 0, 0, 0, 0, 1, 1, "R1");
        idle();
        check(victim_frame == 0, "R4", "empty table victim", victim_frame, 0);
        // R3: reference to absent frame is ignored
        cyc(1, 1, 1, 0, 0, 0, 0, "R3 absent-ref");
        check(frame_modified == 0 && frame_referenced == 0, "R3", "absent ref ignored",
              frame_modified | frame_referenced, 0);
        cyc(0, 0, 0, 1, 2, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, 2, "R2");
        idle();
        check(victim_frame == 0, "R4", "lowest empty", victim_frame, 0);
        cyc(0, 0, 0, 1, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 1, 0, "R2");
        idle();
        check(victim_frame == 1, "R4", "next empty", victim_frame, 1);
        cyc(0, 0, 0, 1, 1, 0, 0, "R2");
        cyc(0, 0, 0, 1, 3, 0, 0, "R2");
        // R11: load and reference to the same frame together
        cyc(1, 3, 1, 1, 3, 0, 0, "R11");
        check(frame_present[3] && !frame_modified[3] && !frame_referenced[3], "R11",
              "load beats reference", {frame_referenced[3], frame_modified[3]}, 0);
        // R10: fault together with a write; victim sees pre-write state
        cyc(1, 2, 1, 0, 0, 1, 0, "R3");
        idle();
        check(victim_frame == 2 && victim_dirty == 0, "R10", "fault with same-cycle write",
              {victim_frame, victim_dirty}, 4);
        // R7: saturation (frame 0 touched 9 times; wrap would make it least used)
        for (int k = 0; k < 9; k++) cyc(1, 0, 0, 0, 0, 0, 0, "R3");
        for (int k = 0; k < 3; k++) cyc(1, 1, 0, 0, 0, 0, 0, "R3");
        for (int k = 0; k < 2; k++) cyc(1, 2, 0, 0, 0, 0, 0, "R3");
        cyc(1, 3, 0, 0, 0, 0, 0, "R3");
        cyc(1, 3, 0, 0, 0, 1, 2, "R3");
        idle();
        // Sweep: interleaved references, loads and faults under every policy code
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0] | lfsr[1], int'(lfsr[3:2]), lfsr[4],
                lfsr[9:7] == 3'd0, int'(lfsr[6:5]),
                lfsr[12:11] == 2'd0, int'(lfsr[14:13]), "R2/R3/R8/R11");
        end
        idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule